// File: doc/BRIEF.md
# Base-Complement Unsigned Multiplier

This block multiplies two unsigned operands of `W` bits (8 by default) by working with their distances from the base 2^W, not by summing a full set of partial products. Each operand is turned into its complement against the base. The two complements are multiplied. The low `W` bits of that complement product become the low half of the result. The high half is the sum of both operands and the upper part of the complement product, minus the base. The two halves are joined into a `2W`-bit product.

The identity behind this is a·b = 2^W·(a + b − 2^W + ⌊c/2^W⌋) + (c mod 2^W), where c = (2^W − a)(2^W − b). Complements are `W+1` bits wide, so a zero operand gives the complement 2^W. The high-part sum is carried in `W+3` bits, so no intermediate value wraps before the base is subtracted.

The block sits in a pipeline with a single register stage. A pair offered with `valid_i` high is captured on the clock edge, and its product appears one cycle later with `valid_o` high. In cycles without `valid_i`, the last product stays on the output.

Top module: `nikhilam_mul`

## Requirements
- R1: One cycle after a clock edge at which `valid_i` is high, `prod_o` equals the unsigned product of the `a_i` and `b_i` sampled at that edge. This holds for every one of the 2^(2W) operand pairs.
- R2: `valid_o` equals the value `valid_i` had at the previous clock edge.
- R3: At an edge where `valid_i` is low, `prod_o` does not change, whatever `a_i` and `b_i` carry.
- R4: While `rst_ni` is low, `valid_o` is 0 and `prod_o` is 0.
- R5: If either operand is 0, the product is 0. This includes both operands being 0, where the complement product is 2^(2W).
- R6: With both operands at their maximum (255 for W=8), the product is 65025.
- R7: The low `W` bits of the product equal the low `W` bits of (2^W − a)·(2^W − b).
- R8: The high `W` bits of the product equal a + b + ⌊(2^W − a)(2^W − b) / 2^W⌋ − 2^W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Operand pair is valid in this cycle |
| a_i | input | W | Multiplicand |
| b_i | input | W | Multiplier |
| valid_o | output | 1 | `prod_o` holds a fresh product |
| prod_o | output | 2W | Registered product |

## Verification
Two things can happen in the same clock edge: a new pair is captured, and the product of the previous pair is presented. A third case is a held cycle, where `valid_i` is low while the operand inputs change. The bench runs every operand pair back to back and inserts an idle cycle after roughly every seventh pair. During each idle cycle it drives scrambled operands. A behavioural reference model is compared against `valid_o` and `prod_o` on every clock. Each valid cycle is also checked against the complement identity for the low half (R7) and the high half (R8).

// File: rtl/nik_pkg.sv
package nik_pkg;
  parameter int unsigned NIK_DEF_W = 8;

  // complement width: one extra bit so that a zero operand maps to the base
  function automatic int unsigned nik_cw(int unsigned w);
    return w + 1;
  endfunction
endpackage

// File: rtl/nik_complement.sv
module nik_complement #(
  parameter int unsigned W = nik_pkg::NIK_DEF_W,
  localparam int unsigned CW = nik_pkg::nik_cw(W)
) (
  input  logic [W-1:0]  op_i,
  output logic [CW-1:0] comp_o
);
  localparam logic [CW-1:0] BASE = {1'b1, {W{1'b0}}};

  assign comp_o = BASE - {1'b0, op_i};
endmodule

// File: rtl/nik_comp_mult.sv
module nik_comp_mult #(
  parameter int unsigned W = nik_pkg::NIK_DEF_W,
  localparam int unsigned CW = nik_pkg::nik_cw(W),
  localparam int unsigned PW = 2 * CW
) (
  input  logic [CW-1:0]  ca_i,
  input  logic [CW-1:0]  cb_i,
  output logic [W-1:0]   lo_o,
  output logic [W+1:0]   hi_o
);
  logic [PW-1:0] cp;

  assign cp   = PW'(ca_i) * PW'(cb_i);
  assign lo_o = cp[W-1:0];
  assign hi_o = cp[PW-1:W];  // includes the 2^(2W) bit for a zero pair
endmodule

// File: rtl/nik_left_adder.sv
module nik_left_adder #(
  parameter int unsigned W = nik_pkg::NIK_DEF_W,
  localparam int unsigned LW = W + 3
) (
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  input  logic [W+1:0]  hi_i,
  output logic [W-1:0]  left_o
);
  localparam logic [LW-1:0] BASE = LW'(1) << W;

  logic [LW-1:0] sum;
  logic          unused_sum_hi;

  assign sum           = LW'(a_i) + LW'(b_i) + LW'(hi_i) - BASE;
  assign left_o        = sum[W-1:0];
  assign unused_sum_hi = ^sum[LW-1:W];  // zero for every legal pair
endmodule

// File: rtl/nikhilam_mul.sv
module nikhilam_mul #(
  parameter int unsigned W = nik_pkg::NIK_DEF_W,
  localparam int unsigned CW = nik_pkg::nik_cw(W)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           valid_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic           valid_o,
  output logic [2*W-1:0] prod_o
);
  logic [1:0][W-1:0]  ops;
  logic [1:0][CW-1:0] comps;
  logic [W-1:0]       right_part;
  logic [W+1:0]       cp_hi;
  logic [W-1:0]       left_part;

  assign ops[0] = a_i;
  assign ops[1] = b_i;

  for (genvar g = 0; g < 2; g++) begin : g_comp
    nik_complement #(.W(W)) u_comp (
      .op_i   (ops[g]),
      .comp_o (comps[g])
    );
  end

  nik_comp_mult #(.W(W)) u_cmul (
    .ca_i (comps[0]),
    .cb_i (comps[1]),
    .lo_o (right_part),
    .hi_o (cp_hi)
  );

  nik_left_adder #(.W(W)) u_left (
    .a_i    (a_i),
    .b_i    (b_i),
    .hi_i   (cp_hi),
    .left_o (left_part)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      prod_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) prod_o <= {left_part, right_part};
    end
  end
endmodule

// File: rtl/nik_mul_chk.sv
module nik_mul_chk #(
  parameter int unsigned W = nik_pkg::NIK_DEF_W
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           valid_i,
  input logic [W-1:0]   a_i,
  input logic [W-1:0]   b_i,
  input logic           valid_o,
  input logic [2*W-1:0] prod_o
);
  localparam int unsigned PW = 2 * W;

  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_state_r4: assert (valid_o == 1'b0 && prod_o == '0)
        else $error("R4 outputs not cleared in reset");
    end
  end

  p_valid_delay_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> valid_o == $past(valid_i));

  p_product_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && valid_o |-> prod_o == PW'($past(a_i)) * PW'($past(b_i)));

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && !$past(valid_i) |-> $stable(prod_o));

  p_zero_operand_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && valid_o && ($past(a_i) == '0 || $past(b_i) == '0) |-> prod_o == '0);
endmodule

bind nikhilam_mul nik_mul_chk #(.W(W)) u_chk (.*);

// File: tb/tb_nikhilam_mul.sv
`timescale 1ns/1ps
module tb_nikhilam_mul;
  localparam int W = 8;
  localparam int B = 1 << W;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic           valid_i = 1'b0;
  logic [W-1:0]   a_i = '0;
  logic [W-1:0]   b_i = '0;
  logic           valid_o;
  logic [2*W-1:0] prod_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // reference model state
  int m_valid = 0;
  int m_prod  = 0;
  int m_a     = 0;
  int m_b     = 0;

  always #2.5 clk_i = ~clk_i;

  nikhilam_mul #(.W(W)) dut (
    .clk_i, .rst_ni, .valid_i, .a_i, .b_i, .valid_o, .prod_o
  );

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_valid <= 0;
      m_prod  <= 0;
    end else begin
      m_valid <= int'(valid_i);
      if (valid_i) begin
        m_prod <= int'(a_i) * int'(b_i);
        m_a    <= int'(a_i);
        m_b    <= int'(b_i);
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic compare_cycle();
    int cp;
    chk("R2 valid_o", int'(valid_o), m_valid);
    if (m_valid == 1) begin
      if (m_a == 0 || m_b == 0) chk("R5 zero operand", int'(prod_o), 0);
      else if (m_a == B-1 && m_b == B-1) chk("R6 max operands", int'(prod_o), (B-1)*(B-1));
      else chk("R1 product", int'(prod_o), m_prod);
      cp = (B - m_a) * (B - m_b);
      chk("R7 low half", int'(prod_o[W-1:0]), cp % B);
      chk("R8 high half", int'(prod_o[2*W-1:W]), m_a + m_b + cp / B - B);
    end else begin
      chk("R3 hold", int'(prod_o), m_prod);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R4 reset valid_o", int'(valid_o), 0);
    chk("R4 reset prod_o", int'(prod_o), 0);
    rst_ni = 1'b1;
    for (int p = 0; p < B * B; p++) begin
      @(negedge clk_i);
      compare_cycle();
      valid_i = 1'b1;
      a_i = W'(p >> W);
      b_i = W'(p);
      if (p % 7 == 3) begin
        @(negedge clk_i);
        compare_cycle();
        valid_i = 1'b0;
        a_i = W'(~p ^ 8'h5a);  // scrambled operands must not reach the output
        b_i = W'(p * 3);
      end
    end
    @(negedge clk_i);
    compare_cycle();
    valid_i = 1'b0;
    repeat (3) begin
      @(negedge clk_i);
      compare_cycle();
    end
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
    end
  end
endmodule